// File: doc/BRIEF.md
# Status-Tagged Receive Queue

This block sits between a serial receiver's shift register and the register interface that software reads. Each character arrives with three quality flags: break detected, framing error and parity error. The block stores those flags beside the character, so they leave the queue with it. The head of the queue is always visible. `rd_data` shows the oldest character and `stat_flags` shows its quality, so software can inspect the status first and then pop the character with `rd_en`.

`blk_mode` selects one of two ways of reporting status. With `blk_mode` low, the status follows whichever character is at the head. With `blk_mode` high, the status is a running OR of the flags of every character written since the last clear-errors command. That command is a `cmd_valid` pulse carrying code 0x04, and it also clears a sticky overrun flag. The overrun flag records characters that were lost because they arrived while the queue was full.

Occupancy is tracked by a three-state machine: EMPTY, PARTIAL and FULL. It has these transitions:
- FIRST_IN: EMPTY to PARTIAL on an accepted write.
- TOP_UP: PARTIAL to FULL when the last free slot is written without a read.
- LAST_OUT: PARTIAL to EMPTY when the last entry is read without a write.
- MAKE_ROOM: FULL to PARTIAL on a read.

In every other case the state holds. The state drives `full` and `empty`, and a separate counter drives `level`.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: A write stores `wr_data` with its flags. The stored flags are presented on `stat_flags` with break on bit 2, framing on bit 1 and parity on bit 0, and they are never mixed with another character's flags.
- R2: Characters leave in the order they were written. `rd_data` shows the oldest stored character combinationally, and a read with `rd_en` removes it at the clock edge. Depth is 16 entries.
- R3: With `blk_mode` low, `stat_flags` equals the flags of the character currently on `rd_data`. The value changes only after the edge that pops that character. It is 0 when the queue is empty.
- R4: With `blk_mode` high, `stat_flags` is the OR of the flags of every write accepted since the last clear, including characters not yet read. A write in the same cycle as a clear is counted after the clear.
- R5: A `cmd_valid` pulse with `cmd_code` 0x04 clears the block-mode accumulator and `overrun` at the next edge. A pulse with any other code has no effect on either.
- R6: A write while `full` is high is dropped: contents and `level` are unchanged. The write sets `overrun`, which stays high until cleared by R5.
- R7: A read while `empty` is high leaves `level` unchanged, and `rd_data` reads 0 whenever the queue is empty.
- R8: `level` counts stored entries from 0 to 16. `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` is 16.
- R9: After reset the queue is empty, `level` is 0, `overrun` is 0 and `stat_flags` is 0 in both modes.
- R10: A read and a write in the same cycle on a partly filled queue both take effect, and `level` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received character |
| wr_brk | input | 1 | Break flag of the character |
| wr_frm | input | 1 | Framing error flag of the character |
| wr_par | input | 1 | Parity error flag of the character |
| rd_en | input | 1 | Pop the head character |
| blk_mode | input | 1 | 1 selects accumulated status, 0 selects per-character status |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code; 0x04 clears errors |
| rd_data | output | 8 | Head character, 0 when empty |
| stat_flags | output | 3 | Status: {break, framing, parity} |
| full | output | 1 | Queue holds 16 entries |
| empty | output | 1 | Queue holds no entries |
| level | output | 5 | Number of stored entries |
| overrun | output | 1 | Sticky: a write was lost while full |

## Verification
The bench fills the queue and then writes past the limit. A design that overwrote the oldest entry, or moved its write pointer on a dropped write, would show the wrong character or the wrong count, and a design without the sticky flag would leave `overrun` low. Pops are interleaved with status checks and the flags differ from character to character. A status delayed by one character, or flags stored out of step with the data, shows up in per-character mode as the neighbour's flags. Block mode is exercised with clears arriving together with writes, with a wrong command code, and with unread characters still queued. An accumulator that captured flags on pop, or that honoured any command, would report a different OR. Reads of an empty queue and simultaneous read and write expose counters that wrap or lose an update.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int FLAG_W = 3;
    localparam int CMD_W  = 8;
    localparam logic [CMD_W-1:0] CMD_CLR_ERR = 8'h04;

    typedef struct packed {
        logic brk;
        logic frm;
        logic par;
    } rxq_flags_t;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_state_t;

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 11,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            unique case ({push, pop})
                2'b10:   level <= level + LW'(1);
                2'b01:   level <= level - LW'(1);
                default: level <= level;
            endcase
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/rxq_occ_fsm.sv
module rxq_occ_fsm
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    occ_state_t state_q;
    occ_state_t state_d;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (push) state_d = (DEPTH == 1) ? OCC_FULL : OCC_PARTIAL;      // FIRST_IN
            end
            OCC_PARTIAL: begin
                if (push && !pop && level == LW'(DEPTH - 1))
                    state_d = OCC_FULL;                                       // TOP_UP
                else if (pop && !push && level == LW'(1))
                    state_d = OCC_EMPTY;                                      // LAST_OUT
            end
            OCC_FULL: begin
                if (pop) state_d = (DEPTH == 1) ? OCC_EMPTY : OCC_PARTIAL;      // MAKE_ROOM
            end
            default: state_d = OCC_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OCC_EMPTY;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   empty = 1'b1;
            OCC_FULL:    full  = 1'b1;
            default:     ;
        endcase
    end

endmodule

// File: rtl/rxq_err_acc.sv
module rxq_err_acc
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       push,
    input  logic       drop,
    input  rxq_flags_t flags_in,
    output rxq_flags_t acc,
    output logic       overrun
);

    rxq_flags_t acc_base;
    logic       ovr_base;

    always_comb begin
        acc_base = clr ? '0 : acc;
        ovr_base = clr ? 1'b0 : overrun;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc     <= '0;
            overrun <= 1'b0;
        end else begin
            acc     <= acc_base | (push ? flags_in : '0);
            overrun <= ovr_base | drop;
        end
    end

endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int EW   = DW + FLAG_W,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    input  logic              wr_brk,
    input  logic              wr_frm,
    input  logic              wr_par,
    input  logic              rd_en,
    input  logic              blk_mode,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    output logic [DW-1:0]     rd_data,
    output logic [FLAG_W-1:0] stat_flags,
    output logic              full,
    output logic              empty,
    output logic [LW-1:0]     level,
    output logic              overrun
);

    logic       push;
    logic       pop;
    logic       drop;
    logic       clr;
    rxq_flags_t in_flags;
    rxq_flags_t head_flags;
    rxq_flags_t acc_flags;
    logic [EW-1:0] wr_entry;
    logic [EW-1:0] head_entry;

    assign push     = wr_en && !full;
    assign drop     = wr_en && full;
    assign pop      = rd_en && !empty;
    assign clr      = cmd_valid && (cmd_code == CMD_CLR_ERR);
    assign in_flags = '{brk: wr_brk, frm: wr_frm, par: wr_par};
    assign wr_entry = {in_flags, wr_data};

    rxq_store #(.DEPTH(DEPTH), .W(EW)) store_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .wdata (wr_entry),
        .head  (head_entry),
        .level (level)
    );

    rxq_occ_fsm #(.DEPTH(DEPTH)) occ_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .level (level),
        .full  (full),
        .empty (empty)
    );

    rxq_err_acc acc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .push     (push),
        .drop     (drop),
        .flags_in (in_flags),
        .acc      (acc_flags),
        .overrun  (overrun)
    );

    assign head_flags = empty ? '0 : rxq_flags_t'(head_entry[EW-1:DW]);
    assign rd_data    = empty ? '0 : head_entry[DW-1:0];
    assign stat_flags = blk_mode ? acc_flags : head_flags;

endmodule

// File: rtl/rxq_tagged_fifo_chk.sv
module rxq_tagged_fifo_chk #(
    parameter int DEPTH = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          blk_mode,
    input logic          cmd_valid,
    input logic [7:0]    cmd_code,
    input logic [7:0]    rd_data,
    input logic [2:0]    stat_flags,
    input logic          full,
    input logic          empty,
    input logic [LW-1:0] level,
    input logic          overrun
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R8
    AST_EMPTY_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (level == '0)); // R8
    AST_FULL_MATCHES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        full == (level == LW'(DEPTH))); // R8
    AST_DROP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> $stable(level)); // R6
    AST_DROP_SETS_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> overrun); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !(cmd_valid && cmd_code == 8'h04)) |=> overrun); // R6
    AST_CLEAR_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == 8'h04 && !wr_en) |=> !overrun); // R5
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == 8'h00)); // R7
    AST_EMPTY_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> $stable(level)); // R7
    AST_PERCHAR_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !blk_mode) |-> (stat_flags == 3'b000)); // R3
    AST_RW_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_en && !full && !empty) |=> $stable(level)); // R10

endmodule

bind rxq_tagged_fifo rxq_tagged_fifo_chk #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .blk_mode   (blk_mode),
    .cmd_valid  (cmd_valid),
    .cmd_code   (cmd_code),
    .rd_data    (rd_data),
    .stat_flags (stat_flags),
    .full       (full),
    .empty      (empty),
    .level      (level),
    .overrun    (overrun)
);

// File: tb/rxq_tagged_fifo_tb.sv
module rxq_tagged_fifo_tb_top;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_brk = 1'b0;
    logic       wr_frm = 1'b0;
    logic       wr_par = 1'b0;
    logic       rd_en = 1'b0;
    logic       blk_mode = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [7:0] cmd_code = '0;
    logic [7:0] rd_data;
    logic [2:0] stat_flags;
    logic       full;
    logic       empty;
    logic [4:0] level;
    logic       overrun;

    always #4 clk = ~clk;   // 125 MHz

    rxq_tagged_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_brk(wr_brk), .wr_frm(wr_frm), .wr_par(wr_par), .rd_en(rd_en),
        .blk_mode(blk_mode), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rd_data(rd_data), .stat_flags(stat_flags), .full(full),
        .empty(empty), .level(level), .overrun(overrun)
    );

    // reference model: queue of {flags, data}
    logic [10:0] mq[$];
    logic [2:0]  m_acc = '0;
    logic        m_ovr = 1'b0;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 1'b0;
    int unsigned lfsr = 32'hACE1_2468;

    task automatic chk(input string req, input string what, input int act, input int exp);
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] e_data;
        logic [2:0] e_stat;
        e_data = (mq.size() == 0) ? 8'h00 : mq[0][7:0];
        e_stat = blk_mode ? m_acc : ((mq.size() == 0) ? 3'b000 : mq[0][10:8]);
        vectors++;
        chk("R2", "rd_data", rd_data, e_data);
        chk(blk_mode ? "R4" : "R3", "stat_flags", stat_flags, e_stat);
        chk("R8", "level", level, mq.size());
        chk("R8", "full", full, mq.size() == DEPTH);
        chk("R8", "empty", empty, mq.size() == 0);
        chk("R6", "overrun", overrun, m_ovr);
    endtask

    task automatic model_edge();
        bit was_full;
        was_full = (mq.size() == DEPTH);
        if (!rst_n) begin
            mq.delete(); m_acc = '0; m_ovr = 1'b0;
            return;
        end
        if (cmd_valid && cmd_code == 8'h04) begin m_acc = '0; m_ovr = 1'b0; end
        if (rd_en && mq.size() > 0) void'(mq.pop_front());
        if (wr_en) begin
            if (was_full) m_ovr = 1'b1;
            else begin
                mq.push_back({wr_brk, wr_frm, wr_par, wr_data});
                m_acc = m_acc | {wr_brk, wr_frm, wr_par};
            end
        end
    endtask

    // one cycle: inputs applied at negedge, model at posedge, compare at next negedge
    task automatic step(input bit w, input logic [7:0] d, input logic [2:0] f,
                        input bit r, input bit cv, input logic [7:0] cc, input bit b);
        wr_en = w; wr_data = d; {wr_brk, wr_frm, wr_par} = f;
        rd_en = r; cmd_valid = cv; cmd_code = cc; blk_mode = b;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        @(negedge clk);
        step(0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 1);
        rst_n = 1'b1;
        // R1 R3: per-character flags follow the head, status seen before pop
        step(1, 8'h41, 3'b000, 0, 0, 0, 0);
        step(1, 8'h42, 3'b001, 0, 0, 0, 0);
        step(1, 8'h43, 3'b010, 0, 0, 0, 0);
        step(1, 8'h44, 3'b100, 0, 0, 0, 0);
        step(1, 8'h45, 3'b111, 0, 0, 0, 0);
        for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0, 0, 0);
        // R7: empty reads
        step(0, 0, 0, 1, 0, 0, 0);
        step(0, 0, 0, 1, 0, 0, 1);
        // R2 R8: fill to the top; R6: writes past full are dropped
        for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h10 + i), 3'(i), 0, 0, 0, 0);
        step(1, 8'hEE, 3'b111, 0, 0, 0, 0);
        step(1, 8'hEF, 3'b000, 0, 0, 0, 1);
        // R4: block mode sees flags of unread characters
        step(0, 0, 0, 0, 0, 0, 1);
        // R5: wrong code ignored, then clear
        step(0, 0, 0, 0, 1, 8'h05, 1);
        step(0, 0, 0, 0, 1, 8'h40, 1);
        step(0, 0, 0, 0, 1, 8'h04, 1);
        // R10: simultaneous read and write while full is a pure pop; then partial
        step(1, 8'h99, 3'b010, 1, 0, 0, 1);
        step(1, 8'h9A, 3'b001, 1, 0, 0, 1);
        step(1, 8'h9B, 3'b000, 1, 0, 0, 0);
        // R4 R5: clear together with a write counts that write
        step(1, 8'h9C, 3'b100, 0, 1, 8'h04, 1);
        step(0, 0, 0, 0, 0, 0, 1);
        // drain
        for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 0, 0, i % 2 == 1);
        // R1 R2 R3 R4 R6 R10: mixed traffic
        for (int i = 0; i < 3000; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            step(lfsr[0] | lfsr[9], lfsr[15:8], lfsr[18:16], lfsr[1] & ~lfsr[10],
                 lfsr[20:19] == 2'b11, (lfsr[21]) ? 8'h04 : 8'h0C, lfsr[22]);
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule